// File: doc/BRIEF.md
# Dual-Modulus Integer-N Feedback Divider

This block is the digital divider chain of an integer-N frequency synthesizer. Everything runs on one system clock. Two enable inputs mark the edges being divided. `vcoEn` marks one edge of the oscillator being synthesized, and `refEn` marks one edge of the reference.

On the feedback path, a prescaler counts oscillator edges. It divides by 10 or by 11, as chosen by a modulus-select signal. A main counter counts prescaler periods, and a swallow counter keeps the prescaler at 11 for the first A of those periods. The total feedback divide is therefore 10·(M+1)+A. A bypass setting skips the prescaler and divides by M+1 directly. On the reference path, a separate counter divides by R+1.

Both dividers report one single-cycle pulse per period. New divide settings normally wait for the end of the period in progress, so no period is ever cut short. An immediate-load control makes them apply at once instead. A power-down input clears the whole chain and silences its outputs.

Top module: `intn_div_chain`

## Requirements
- R1: With bypass low, `fp` pulses once every 10·(M+1)+A counted `vcoEn` cycles, for 1 ≤ M ≤ 511 and 0 ≤ A ≤ M+1. Each pulse is one clock cycle wide and appears one clock after the terminal `vcoEn` cycle.
- R2: Within each feedback period, `modSel` is high for the first 11·A counted input edges and low for the remaining edges. This means the prescaler divides by 11 for A prescaler periods and by 10 for the others.
- R3: The boundary settings hold. M = 1 gives a main divide of 2, so the period is 20+A. A = M+1 keeps `modSel` high for the whole period.
- R4: With bypass high, `fp` pulses once every M+1 counted `vcoEn` cycles, and `modSel` stays low.
- R5: `fc` pulses once every R+1 counted `refEn` cycles, for 0 ≤ R ≤ 63. With R = 0, `fc` pulses one clock after every `refEn` cycle.
- R6: With `loadNow` low, new values of M, A and bypass take effect only at the next `fp` terminal count. A new R takes effect only at the next `fc` terminal count. The period in progress keeps its old length.
- R7: With `loadNow` high, new settings take effect within one clock, and the period in progress is cut short when its count already meets the new limit.
- R8: While `pwrDn` is high, every counter stays cleared, and `fp`, `fc` and `modSel` stay low. After `pwrDn` falls, the first bypass `fp` arrives M+2 clocks later, because counting restarts from zero.
- R9: While `rstN` is low, `fp`, `fc` and `modSel` are low.
- R10: Clock cycles with `vcoEn` low are not counted. With `vcoEn` high every g-th cycle, the `fp` period is g times the divide ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDn | input | 1 | Power-down: clears and silences the chain |
| loadNow | input | 1 | Apply new settings every cycle instead of at terminal count |
| bypass | input | 1 | 1 = divide by M+1 with the prescaler unused |
| mDiv | input | 9 | Main counter setting M |
| aSwallow | input | 4 | Swallow count A |
| rDiv | input | 6 | Reference divider setting R |
| vcoEn | input | 1 | One oscillator edge to be counted |
| refEn | input | 1 | One reference edge to be counted |
| fp | output | 1 | Feedback divider pulse |
| fc | output | 1 | Reference divider pulse |
| modSel | output | 1 | Prescaler modulus select, 1 = divide by 11 |

## Verification
Every output is registered, so a pulse appears one clock after the edge of its terminal input cycle. The bench samples at the falling edge and measures periods as the gap between two pulses, which makes that fixed latency cancel out. The `modSel` high time is counted inside the same window, where its one-cycle lag also cancels. After power-down is released, a pulse is due M+2 clocks later: one clock to re-arm the settings, one to leave the cleared state, and M more before the terminal count. The bench checks the exact cycle index at which that first pulse appears.

// File: rtl/divchain_pkg.sv
package divchain_pkg;
  typedef struct packed {
    logic clrAll;
    logic preStep;
    logic preWrap;
    logic mainStep;
    logic mainWrap;
    logic swStep;
    logic refStep;
    logic refWrap;
    logic modSel;
  } divStrobe_t;
endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divchain_pkg::*;
#(
  parameter int M_W = 9,
  parameter int A_W = 4,
  parameter int R_W = 6,
  parameter int PRE_BASE = 10,
  localparam int P_W = $clog2(PRE_BASE + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pwrDn,
  input  logic           loadNow,
  input  logic           bypassIn,
  input  logic [M_W-1:0] mIn,
  input  logic [A_W-1:0] aIn,
  input  logic [R_W-1:0] rIn,
  input  logic           vcoEn,
  input  logic           refEn,
  input  logic [P_W-1:0] preCnt,
  input  logic [M_W-1:0] mainCnt,
  input  logic [A_W-1:0] swCnt,
  input  logic [R_W-1:0] refCnt,
  output divStrobe_t     stb
);
  localparam logic [P_W-1:0] LAST_LONG  = P_W'(PRE_BASE);
  localparam logic [P_W-1:0] LAST_SHORT = P_W'(PRE_BASE - 1);

  logic [M_W-1:0] mAct;
  logic [A_W-1:0] aAct;
  logic [R_W-1:0] rAct;
  logic bypAct, primed;
  logic run, sel, preTick;
  logic [P_W-1:0] preLast;

  // Active settings: armed after reset or power-down, then refreshed at
  // terminal count, or every cycle in immediate mode.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAct   <= '0;
      aAct   <= '0;
      rAct   <= '0;
      bypAct <= 1'b0;
      primed <= 1'b0;
    end else if (pwrDn) begin
      primed <= 1'b0;
    end else if (!primed || loadNow) begin
      mAct   <= mIn;
      aAct   <= aIn;
      rAct   <= rIn;
      bypAct <= bypassIn;
      primed <= 1'b1;
    end else begin
      if (stb.mainWrap) begin
        mAct   <= mIn;
        aAct   <= aIn;
        bypAct <= bypassIn;
      end
      if (stb.refWrap) rAct <= rIn;
    end
  end

  always_comb begin
    run     = primed & ~pwrDn;
    sel     = run & ~bypAct & (swCnt < aAct);
    preLast = sel ? LAST_LONG : LAST_SHORT;
    preTick = run & vcoEn & (bypAct | (preCnt >= preLast));

    stb.clrAll   = ~run;
    stb.preStep  = run & vcoEn & ~bypAct;
    stb.preWrap  = preTick & ~bypAct;
    stb.mainStep = preTick;
    stb.mainWrap = preTick & (mainCnt >= mAct);
    stb.swStep   = preTick & sel;
    stb.refStep  = run & refEn;
    stb.refWrap  = run & refEn & (refCnt >= rAct);
    stb.modSel   = sel;
  end
endmodule

// File: rtl/divPath.sv
module divPath
  import divchain_pkg::*;
#(
  parameter int M_W = 9,
  parameter int A_W = 4,
  parameter int R_W = 6,
  parameter int PRE_BASE = 10,
  localparam int P_W = $clog2(PRE_BASE + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  divStrobe_t     stb,
  output logic [P_W-1:0] preCnt,
  output logic [M_W-1:0] mainCnt,
  output logic [A_W-1:0] swCnt,
  output logic [R_W-1:0] refCnt,
  output logic           fpQ,
  output logic           fcQ,
  output logic           selQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         preCnt <= '0;
    else if (stb.clrAll || stb.preWrap) preCnt <= '0;
    else if (stb.preStep)              preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           mainCnt <= '0;
    else if (stb.clrAll || stb.mainWrap) mainCnt <= '0;
    else if (stb.mainStep)               mainCnt <= mainCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           swCnt <= '0;
    else if (stb.clrAll || stb.mainWrap) swCnt <= '0;
    else if (stb.swStep)                 swCnt <= swCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          refCnt <= '0;
    else if (stb.clrAll || stb.refWrap) refCnt <= '0;
    else if (stb.refStep)               refCnt <= refCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fpQ  <= 1'b0;
      fcQ  <= 1'b0;
      selQ <= 1'b0;
    end else begin
      fpQ  <= stb.mainWrap;
      fcQ  <= stb.refWrap;
      selQ <= stb.modSel;
    end
  end
endmodule

// File: rtl/intn_div_chain.sv
module intn_div_chain
  import divchain_pkg::*;
#(
  parameter int M_W = 9,
  parameter int A_W = 4,
  parameter int R_W = 6,
  parameter int PRE_BASE = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pwrDn,
  input  logic           loadNow,
  input  logic           bypass,
  input  logic [M_W-1:0] mDiv,
  input  logic [A_W-1:0] aSwallow,
  input  logic [R_W-1:0] rDiv,
  input  logic           vcoEn,
  input  logic           refEn,
  output logic           fp,
  output logic           fc,
  output logic           modSel
);
  localparam int P_W = $clog2(PRE_BASE + 1);

  divStrobe_t     stb;
  logic [P_W-1:0] preCnt;
  logic [M_W-1:0] mainCnt;
  logic [A_W-1:0] swCnt;
  logic [R_W-1:0] refCnt;

  divCtrl #(.M_W(M_W), .A_W(A_W), .R_W(R_W), .PRE_BASE(PRE_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrDn(pwrDn), .loadNow(loadNow),
    .bypassIn(bypass), .mIn(mDiv), .aIn(aSwallow), .rIn(rDiv),
    .vcoEn(vcoEn), .refEn(refEn), .preCnt(preCnt), .mainCnt(mainCnt),
    .swCnt(swCnt), .refCnt(refCnt), .stb(stb)
  );

  divPath #(.M_W(M_W), .A_W(A_W), .R_W(R_W), .PRE_BASE(PRE_BASE)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .preCnt(preCnt), .mainCnt(mainCnt),
    .swCnt(swCnt), .refCnt(refCnt), .fpQ(fp), .fcQ(fc), .selQ(modSel)
  );
endmodule

// File: rtl/divChainChk.sv
module divChainChk (
  input logic clk,
  input logic rstN,
  input logic pwrDn,
  input logic vcoEn,
  input logic refEn,
  input logic fp,
  input logic fc,
  input logic modSel
);
  // R8
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrDn |=> (!fp && !fc && !modSel));

  // R1
  fp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fp |=> !fp);

  // R10
  fp_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    fp |-> $past(vcoEn));

  // R5
  fc_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    fc |-> $past(refEn));
endmodule

bind intn_div_chain divChainChk u_chk (
  .clk(clk), .rstN(rstN), .pwrDn(pwrDn), .vcoEn(vcoEn), .refEn(refEn),
  .fp(fp), .fc(fc), .modSel(modSel)
);

// File: tb/sim_intn_div_chain.sv
module sim_intn_div_chain;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;
  localparam int WAIT_MAX = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrDn = 1'b0;
  logic loadNow = 1'b0;
  logic bypass = 1'b0;
  logic [8:0] mDiv = 9'd4;
  logic [3:0] aSwallow = 4'd0;
  logic [5:0] rDiv = 6'd0;
  logic vcoEn = 1'b0;
  logic refEn = 1'b0;
  logic fp, fc, modSel;

  int total = 0;
  int bad = 0;
  int vcoGap = 1;
  int refGap = 1;

  intn_div_chain u0 (
    .clk(clk), .rstN(rstN), .pwrDn(pwrDn), .loadNow(loadNow),
    .bypass(bypass), .mDiv(mDiv), .aSwallow(aSwallow), .rDiv(rDiv),
    .vcoEn(vcoEn), .refEn(refEn), .fp(fp), .fc(fc), .modSel(modSel)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1 >= vcoGap) ? 0 : ph + 1;
      vcoEn = (ph == 0);
    end
  end

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1 >= refGap) ? 0 : ph + 1;
      refEn = (ph == 0);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitFp();
    for (int i = 0; i < WAIT_MAX; i++) begin
      @(negedge clk);
      if (fp) return;
    end
    chk("waitFp timeout", 0, 1);
  endtask

  task automatic waitFc();
    for (int i = 0; i < WAIT_MAX; i++) begin
      @(negedge clk);
      if (fc) return;
    end
    chk("waitFc timeout", 0, 1);
  endtask

  // Called just after an fp was seen; counts cycles to the next fp.
  task automatic fpInterval(output int n, output int selN);
    n = 0;
    selN = 0;
    for (int i = 0; i < WAIT_MAX; i++) begin
      @(negedge clk);
      n++;
      if (modSel) selN++;
      if (fp) return;
    end
  endtask

  task automatic fcInterval(output int n);
    n = 0;
    for (int i = 0; i < WAIT_MAX; i++) begin
      @(negedge clk);
      n++;
      if (fc) return;
    end
  endtask

  task automatic feedMeasure(input string tag, input int expN, input int expSel);
    int n, s;
    waitFp();
    fpInterval(n, s);
    chk({tag, " period"}, n, expN);
    if (expSel >= 0) chk({tag, " modSel"}, s, expSel);
  endtask

  task automatic testReset();
    repeat (4) @(negedge clk);
    chk("R9 fp in reset", int'(fp), 0);
    chk("R9 fc in reset", int'(fc), 0);
    chk("R9 modSel in reset", int'(modSel), 0);
    rstN = 1'b1;
  endtask

  task automatic testPrescaled();
    bypass = 1'b0; mDiv = 9'd4; aSwallow = 4'd3; vcoGap = 1;
    waitFp();
    feedMeasure("R1 R2 M4 A3", 53, 33);
    mDiv = 9'd7; aSwallow = 4'd0;
    waitFp();
    feedMeasure("R1 R2 M7 A0", 80, 0);
  endtask

  task automatic testBounds();
    mDiv = 9'd1; aSwallow = 4'd0;
    waitFp();
    feedMeasure("R3 M1 A0", 20, 0);
    mDiv = 9'd1; aSwallow = 4'd2;
    waitFp();
    feedMeasure("R3 M1 A2", 22, 22);
  endtask

  task automatic testBypass();
    bypass = 1'b1; mDiv = 9'd6;
    waitFp();
    feedMeasure("R4 M6", 7, 0);
    mDiv = 9'd1;
    waitFp();
    feedMeasure("R4 M1", 2, 0);
  endtask

  task automatic testGap();
    bypass = 1'b0; mDiv = 9'd1; aSwallow = 4'd2; vcoGap = 3;
    waitFp();
    waitFp();
    feedMeasure("R10 gap3", 66, 66);
    vcoGap = 1;
  endtask

  task automatic testRef();
    int n;
    refGap = 1; rDiv = 6'd5;
    waitFc();
    waitFc();
    fcInterval(n);
    chk("R5 R=5", n, 6);
    waitFc();
    rDiv = 6'd63;
    fcInterval(n);
    chk("R6 R old period kept", n, 6);
    fcInterval(n);
    chk("R5 R=63", n, 64);
    rDiv = 6'd0;
    waitFc();
    waitFc();
    fcInterval(n);
    chk("R5 R=0 passthrough", n, 1);
    refGap = 4;
    waitFc();
    fcInterval(n);
    chk("R5 R=0 sparse ref", n, 4);
    refGap = 1; rDiv = 6'd2;
  endtask

  task automatic testDefer();
    int n, s;
    bypass = 1'b0; mDiv = 9'd4; aSwallow = 4'd3;
    waitFp();
    waitFp();
    mDiv = 9'd2; aSwallow = 4'd1;
    fpInterval(n, s);
    chk("R6 deferred old period", n, 53);
    fpInterval(n, s);
    chk("R6 deferred new period", n, 31);
    chk("R2 deferred new modSel", s, 11);
  endtask

  task automatic testImmediate();
    int n, s;
    bypass = 1'b1; mDiv = 9'd20; loadNow = 1'b1;
    waitFp();
    waitFp();
    repeat (3) @(negedge clk);
    mDiv = 9'd5;
    fpInterval(n, s);
    chk("R7 truncated period", int'(n < 18), 1);
    fpInterval(n, s);
    chk("R7 new period", n, 6);
    loadNow = 1'b0;
  endtask

  task automatic testPowerDown();
    int n, hits;
    bypass = 1'b1; mDiv = 9'd6; rDiv = 6'd2;
    waitFp();
    waitFp();
    pwrDn = 1'b1;
    @(negedge clk);
    hits = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (fp || fc || modSel) hits++;
    end
    chk("R8 outputs quiet in power-down", hits, 0);
    pwrDn = 1'b0;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (fp) break;
    end
    chk("R8 first fp after release", n, 8);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testPrescaled();
    testBounds();
    testBypass();
    testGap();
    testRef();
    testDefer();
    testImmediate();
    testPowerDown();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule